// File: doc/BRIEF.md
# Weighted Least-Frequently-Used Victim Selector

This block chooses which way of one cache set to replace. It keeps a smoothed frequency weight for each way rather than a plain hit count. The set has one running stamp counter that moves forward by a fixed step of 1000 on every access to any way. When a way is accessed, its weight is recomputed as the access-count-weighted average of its old weight and the current stamp. A way that is used often and recently therefore carries a high weight. A way touched only a few times, or long ago, keeps a low weight and becomes the victim.

The average needs a true division. A restoring divider computes it one quotient bit per clock, and the block reports `busy_o` while the divider runs. While busy, the block ignores every request. The surrounding controller issues an access, fill, invalidate or victim request only while `busy_o` is low.

An optional coherence-aware mode lets the caller pass per-way shared and owned flags. In that mode, ways with neither flag set are evicted before flagged ways. Inside each group the weight still decides. Invalid ways are always chosen before any valid way.

Top module: `wlfu_set_repl`

## Requirements
- R1: After reset, every way is invalid with access count 0 and weight 0, the set stamp is 0, `busy_o` is low and `victim_valid_o` is low.
- R2: Each accepted access first uses the current set stamp in the weight update, then advances the stamp by 1000. The stamp saturates at 2^WGT_W-1 instead of wrapping.
- R3: An access to way A with count n and weight w sets the weight to floor((n*w + stamp)/(n+1)). The count n then increments and saturates at 2^CNT_W-1.
- R4: `busy_o` rises in the cycle after an accepted access and stays high for exactly CNT_W+WGT_W+2 cycles. The updated weight is in force once `busy_o` is low again.
- R5: While `busy_o` is high, access, fill, invalidate and victim requests have no effect: no weight, count, valid bit or stamp changes, and no victim is reported.
- R6: A fill marks the way valid, clears its count to 0 and sets its weight to the current stamp. A fill does not advance the stamp.
- R7: An invalidate clears the way's valid bit. When any way is invalid, the victim is the lowest-indexed invalid way.
- R8: When all ways are valid, the victim is the way with the lowest weight. Ties go to the lowest way index.
- R9: With `coh_mode_i` high, a way whose `shared_i` or `owned_i` bit is set is chosen only if every valid way is flagged. With `coh_mode_i` low, both flag vectors are ignored.
- R10: A `vreq_i` sampled while `busy_o` is low produces a one-cycle `victim_valid_o` pulse in the next cycle, with the chosen way on `victim_way_o`.
- R11: Only one update is taken per cycle. Access has priority over fill, and fill has priority over invalidate. The lower-priority request in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coh_mode_i | input | 1 | Coherence-aware victim ordering enable |
| touch_i | input | 1 | Access strobe |
| touch_way_i | input | $clog2(WAYS) | Way being accessed |
| fill_i | input | 1 | Fill strobe |
| fill_way_i | input | $clog2(WAYS) | Way being filled |
| drop_i | input | 1 | Invalidate strobe |
| drop_way_i | input | $clog2(WAYS) | Way being invalidated |
| shared_i | input | WAYS | Per-way shared flag |
| owned_i | input | WAYS | Per-way owned flag |
| vreq_i | input | 1 | Victim request |
| busy_o | output | 1 | Weight division in progress |
| victim_valid_o | output | 1 | Victim result strobe |
| victim_way_o | output | $clog2(WAYS) | Chosen victim way |

## Verification
The bench keeps its own per-way weight, count and stamp model and checks the reported victim after every update. The access patterns are chosen to separate a true running average from a plain hit counter:
- One way is accessed heavily while the others are accessed rarely.
- Accesses are interleaved across ways, so that stamp spacing matters.
- A heavily used way is refilled, which shows that its history is discarded.

Dedicated sequences cover the following:
- They run the stamp and the access counts into saturation, so that wrapping would move the victim to the wrong way.
- They toggle the shared and owned flags with the mode on and off, so that ignoring or misranking the flags shows up.
- They pulse requests during a division and set simultaneous strobes, which shows whether an update leaks through while busy or the priority order is wrong.

// File: rtl/wlfu_pkg.sv
package wlfu_pkg;

    // Kind of state update taken in a cycle
    typedef enum logic [1:0] {
        OP_IDLE,
        OP_TOUCH,
        OP_FILL,
        OP_DROP
    } op_kind_e;

    // Access outranks fill, fill outranks invalidate
    function automatic op_kind_e pick_op(input logic touch,
                                         input logic fill,
                                         input logic drop);
        if (touch)      return OP_TOUCH;
        else if (fill)  return OP_FILL;
        else if (drop)  return OP_DROP;
        else            return OP_IDLE;
    endfunction

endpackage

// File: rtl/wlfu_div.sv
module wlfu_div #(
    parameter int NUM_W = 33,
    parameter int DEN_W = 9,
    parameter int QUO_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [QUO_W-1:0] quo_o
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [DEN_W:0]    rem_q;
    logic [NUM_W-1:0]  shq_q;
    logic [DEN_W-1:0]  den_q;
    logic [STEP_W-1:0] step_q;
    logic              busy_q;
    logic              done_q;
    logic [QUO_W-1:0]  quo_q;

    logic [DEN_W:0]    trial;
    logic              ge;
    logic [DEN_W:0]    rem_n;
    logic [NUM_W-1:0]  shq_n;
    logic [QUO_W-1:0]  quo_clamped;

    // One restoring step: bring in the next dividend bit, subtract if it fits
    always_comb begin
        trial = {rem_q[DEN_W-1:0], shq_q[NUM_W-1]};
        ge    = (trial >= {1'b0, den_q});
        rem_n = ge ? (trial - {1'b0, den_q}) : trial;
        shq_n = {shq_q[NUM_W-2:0], ge};
        if (|shq_n[NUM_W-1:QUO_W])
            quo_clamped = '1;
        else
            quo_clamped = shq_n[QUO_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            shq_q  <= '0;
            den_q  <= '0;
            step_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            quo_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (start_i && !busy_q) begin
                rem_q  <= '0;
                shq_q  <= num_i;
                den_q  <= den_i;
                step_q <= STEP_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q  <= rem_n;
                shq_q  <= shq_n;
                step_q <= step_q - STEP_W'(1);
                if (step_q == STEP_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    quo_q  <= quo_clamped;
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign done_o = done_q;
    assign quo_o  = quo_q;

    // R4
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(busy_o));

    // R5
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !(start_i && busy_o));

    // R3
    rem_below_div_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (rem_q < {1'b0, den_q}));

endmodule

// File: rtl/wlfu_pick.sv
module wlfu_pick #(
    parameter int WAYS  = 8,
    parameter int WGT_W = 24,
    parameter int IDX_W = 3
) (
    input  logic [WAYS-1:0]             valid_i,
    input  logic [WAYS-1:0]             cls_i,
    input  logic [WAYS-1:0][WGT_W-1:0]  wgt_i,
    output logic [IDX_W-1:0]            way_o
);
    localparam int KEY_W = WGT_W + 2;

    logic [WAYS-1:0][KEY_W-1:0] key;

    // Lower key wins: invalid ways rank 0, then unflagged, then flagged, then weight
    for (genvar g = 0; g < WAYS; g++) begin : g_key
        assign key[g] = valid_i[g] ? {1'b1, cls_i[g], wgt_i[g]} : '0;
    end

    always_comb begin
        logic [KEY_W-1:0] best_key;
        best_key = key[0];
        way_o    = '0;
        for (int i = 1; i < WAYS; i++) begin
            if (key[i] < best_key) begin
                best_key = key[i];
                way_o    = IDX_W'(i);
            end
        end
    end

    // R7
    always_comb begin
        if (!(&valid_i)) begin
            invalid_first_chk: assert (!valid_i[way_o]);
        end
    end

endmodule

// File: rtl/wlfu_set_repl.sv
module wlfu_set_repl #(
    parameter int WAYS  = 8,
    parameter int WGT_W = 24,
    parameter int CNT_W = 8,
    parameter int STEP  = 1000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     coh_mode_i,
    input  logic                     touch_i,
    input  logic [$clog2(WAYS)-1:0]  touch_way_i,
    input  logic                     fill_i,
    input  logic [$clog2(WAYS)-1:0]  fill_way_i,
    input  logic                     drop_i,
    input  logic [$clog2(WAYS)-1:0]  drop_way_i,
    input  logic [WAYS-1:0]          shared_i,
    input  logic [WAYS-1:0]          owned_i,
    input  logic                     vreq_i,
    output logic                     busy_o,
    output logic                     victim_valid_o,
    output logic [$clog2(WAYS)-1:0]  victim_way_o
);
    import wlfu_pkg::*;

    localparam int IDX_W = $clog2(WAYS);
    localparam int DEN_W = CNT_W + 1;
    localparam int NUM_W = CNT_W + WGT_W + 1;
    localparam logic [WGT_W-1:0] WMAX   = '1;
    localparam logic [CNT_W-1:0] CMAX   = '1;
    localparam logic [WGT_W-1:0] STEP_V = WGT_W'(STEP);

    logic [WAYS-1:0]             valid_q;
    logic [WAYS-1:0][WGT_W-1:0]  wgt_q;
    logic [WAYS-1:0][CNT_W-1:0]  cnt_q;
    logic [WGT_W-1:0]            stamp_q;
    logic [IDX_W-1:0]            pend_way_q;
    logic                        vvalid_q;
    logic [IDX_W-1:0]            vway_q;

    logic                        div_busy;
    logic                        div_done;
    logic [WGT_W-1:0]            div_quo;
    logic [NUM_W-1:0]            div_num;
    logic [DEN_W-1:0]            div_den;
    op_kind_e                    op;
    logic [WAYS-1:0]             cls;
    logic [IDX_W-1:0]            pick_way;
    logic [WGT_W-1:0]            stamp_next;

    assign busy_o = div_busy | div_done;
    assign op     = busy_o ? OP_IDLE : pick_op(touch_i, fill_i, drop_i);

    // Numerator n*w + stamp and divisor n+1 for the touched way
    always_comb begin
        logic [NUM_W-1:0] prod;
        prod    = NUM_W'(cnt_q[touch_way_i]) * NUM_W'(wgt_q[touch_way_i]);
        div_num = prod + NUM_W'(stamp_q);
        div_den = DEN_W'(cnt_q[touch_way_i]) + DEN_W'(1);
    end

    // Stamp advance with saturation
    always_comb begin
        if (stamp_q > (WMAX - STEP_V))
            stamp_next = WMAX;
        else
            stamp_next = stamp_q + STEP_V;
    end

    // Coherence class: flagged ways rank after clean ones only in coherence mode
    for (genvar g = 0; g < WAYS; g++) begin : g_cls
        assign cls[g] = coh_mode_i & (shared_i[g] | owned_i[g]);
    end

    wlfu_div #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W),
        .QUO_W (WGT_W)
    ) u_div (
        .clk     (clk),
        .rst     (rst),
        .start_i (op == OP_TOUCH),
        .num_i   (div_num),
        .den_i   (div_den),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    wlfu_pick #(
        .WAYS  (WAYS),
        .WGT_W (WGT_W),
        .IDX_W (IDX_W)
    ) u_pick (
        .valid_i (valid_q),
        .cls_i   (cls),
        .wgt_i   (wgt_q),
        .way_o   (pick_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q    <= '0;
            wgt_q      <= '0;
            cnt_q      <= '0;
            stamp_q    <= '0;
            pend_way_q <= '0;
        end else begin
            unique case (op)
                OP_TOUCH: begin
                    pend_way_q <= touch_way_i;
                    stamp_q    <= stamp_next;
                end
                OP_FILL: begin
                    valid_q[fill_way_i] <= 1'b1;
                    cnt_q[fill_way_i]   <= '0;
                    wgt_q[fill_way_i]   <= stamp_q;
                end
                OP_DROP: begin
                    valid_q[drop_way_i] <= 1'b0;
                end
                default: ;
            endcase
            if (div_done) begin
                wgt_q[pend_way_q] <= div_quo;
                if (cnt_q[pend_way_q] != CMAX)
                    cnt_q[pend_way_q] <= cnt_q[pend_way_q] + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vvalid_q <= 1'b0;
            vway_q   <= '0;
        end else begin
            vvalid_q <= vreq_i && !busy_o;
            if (vreq_i && !busy_o)
                vway_q <= pick_way;
        end
    end

    assign victim_valid_o = vvalid_q;
    assign victim_way_o   = vway_q;

    // R10
    victim_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        victim_valid_o |-> $past(vreq_i && !busy_o));

    // R2
    stamp_monotonic_chk: assert property (@(posedge clk) disable iff (rst)
        stamp_q >= $past(stamp_q));

    // R5
    weights_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !div_done) |=> ($stable(wgt_q) && $stable(cnt_q) && $stable(valid_q)));

    // R5
    stamp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(stamp_q));

endmodule

// File: tb/test_wlfu_set_repl.sv
`timescale 1ns/1ps
module test_wlfu_set_repl;
    localparam int WAYS  = 4;
    localparam int WGT_W = 16;
    localparam int CNT_W = 4;
    localparam int IDX_W = 2;
    localparam int WMAXI = (1 << WGT_W) - 1;
    localparam int CMAXI = (1 << CNT_W) - 1;
    localparam int BUSY_LEN = CNT_W + WGT_W + 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             coh_mode_i = 1'b0;
    logic             touch_i = 1'b0;
    logic [IDX_W-1:0] touch_way_i = '0;
    logic             fill_i = 1'b0;
    logic [IDX_W-1:0] fill_way_i = '0;
    logic             drop_i = 1'b0;
    logic [IDX_W-1:0] drop_way_i = '0;
    logic [WAYS-1:0]  shared_i = '0;
    logic [WAYS-1:0]  owned_i = '0;
    logic             vreq_i = 1'b0;
    logic             busy_o;
    logic             victim_valid_o;
    logic [IDX_W-1:0] victim_way_o;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // Reference state derived from the requirements
    bit m_valid [WAYS];
    int m_w     [WAYS];
    int m_n     [WAYS];
    int m_s;

    always #4 clk = ~clk;

    wlfu_set_repl #(.WAYS(WAYS), .WGT_W(WGT_W), .CNT_W(CNT_W), .STEP(1000)) i_wlfu_set_repl (
        .clk(clk), .rst(rst), .coh_mode_i(coh_mode_i),
        .touch_i(touch_i), .touch_way_i(touch_way_i),
        .fill_i(fill_i), .fill_way_i(fill_way_i),
        .drop_i(drop_i), .drop_way_i(drop_way_i),
        .shared_i(shared_i), .owned_i(owned_i),
        .vreq_i(vreq_i), .busy_o(busy_o),
        .victim_valid_o(victim_valid_o), .victim_way_o(victim_way_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void m_touch(input int a);
        int q;
        q = (m_n[a] * m_w[a] + m_s) / (m_n[a] + 1);
        m_w[a] = (q > WMAXI) ? WMAXI : q;
        m_n[a] = (m_n[a] == CMAXI) ? CMAXI : m_n[a] + 1;
        m_s = (m_s > WMAXI - 1000) ? WMAXI : m_s + 1000;
    endfunction

    function automatic int m_victim();
        longint best;
        int bw;
        best = -1; bw = 0;
        for (int i = 0; i < WAYS; i++) begin
            longint k;
            int c;
            c = (coh_mode_i && (shared_i[i] || owned_i[i])) ? 1 : 0;
            k = m_valid[i] ? ((longint'(2 + c) << WGT_W) + m_w[i]) : 0;
            if (best < 0 || k < best) begin best = k; bw = i; end
        end
        return bw;
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
    endtask

    task automatic do_touch(input int a);
        @(negedge clk); touch_i = 1'b1; touch_way_i = IDX_W'(a);
        @(negedge clk); touch_i = 1'b0;
        while (busy_o) @(negedge clk);
        m_touch(a);
    endtask

    task automatic do_fill(input int a);
        @(negedge clk); fill_i = 1'b1; fill_way_i = IDX_W'(a);
        @(negedge clk); fill_i = 1'b0;
        m_valid[a] = 1'b1; m_n[a] = 0; m_w[a] = m_s;
    endtask

    task automatic do_drop(input int a);
        @(negedge clk); drop_i = 1'b1; drop_way_i = IDX_W'(a);
        @(negedge clk); drop_i = 1'b0;
        m_valid[a] = 1'b0;
    endtask

    // R10: pulse one cycle after the request, way compared with the model
    task automatic ask_victim(input string req);
        int exp;
        exp = m_victim();
        @(negedge clk); vreq_i = 1'b1;
        @(negedge clk); vreq_i = 1'b0;
        check(victim_valid_o == 1'b1, "R10 victim strobe", int'(victim_valid_o), 1);
        check(int'(victim_way_o) == exp, req, int'(victim_way_o), exp);
        @(negedge clk);
        check(victim_valid_o == 1'b0, "R10 single-cycle strobe", int'(victim_valid_o), 0);
    endtask

    task automatic t_reset();
        check(busy_o == 1'b0, "R1 busy after reset", int'(busy_o), 0);
        check(victim_valid_o == 1'b0, "R1 victim strobe after reset", int'(victim_valid_o), 0);
        ask_victim("R1 R7 all invalid picks way 0");
    endtask

    task automatic t_fill_all();
        for (int i = 0; i < WAYS; i++) do_fill(i);
        ask_victim("R6 R8 equal weights tie to lowest index");
    endtask

    task automatic t_busy_timing();
        int len;
        @(negedge clk); touch_i = 1'b1; touch_way_i = 2'd0;
        @(negedge clk); touch_i = 1'b0;
        len = 0;
        while (busy_o) begin len++; @(negedge clk); end
        m_touch(0);
        check(len == BUSY_LEN, "R4 busy length", len, BUSY_LEN);
        ask_victim("R3 R4 weight after first access");
    endtask

    task automatic t_ignore_busy();
        int seen;
        @(negedge clk); touch_i = 1'b1; touch_way_i = 2'd1;
        @(negedge clk); touch_i = 1'b0;
        seen = 0;
        touch_i = 1'b1; touch_way_i = 2'd3;
        fill_i = 1'b1; fill_way_i = 2'd2;
        vreq_i = 1'b1;
        @(negedge clk);
        if (victim_valid_o) seen++;
        touch_i = 1'b0; fill_i = 1'b0; vreq_i = 1'b0;
        drop_i = 1'b1; drop_way_i = 2'd0;
        @(negedge clk);
        if (victim_valid_o) seen++;
        drop_i = 1'b0;
        while (busy_o) @(negedge clk);
        m_touch(1);
        check(seen == 0, "R5 no victim while busy", seen, 0);
        ask_victim("R5 requests during division ignored");
    endtask

    task automatic t_pattern();
        for (int r = 0; r < 4; r++) begin
            do_touch(0);
            do_touch(0);
            do_touch(r % 2 == 0 ? 2 : 3);
            ask_victim("R3 R8 skewed access pattern");
        end
        do_touch(1); do_touch(2); do_touch(3); do_touch(1);
        ask_victim("R3 R8 interleaved access pattern");
    endtask

    task automatic t_refill();
        int v;
        v = m_victim();
        do_fill(0);
        ask_victim("R6 refill replaces history with stamp");
        do_fill(v);
        ask_victim("R6 refill of victim way");
    endtask

    task automatic t_drop();
        do_drop(2);
        ask_victim("R7 single invalid way chosen");
        do_drop(1);
        ask_victim("R7 lowest invalid way chosen");
        do_fill(1); do_fill(2);
        ask_victim("R6 refilled ways");
    endtask

    task automatic t_coh();
        int v;
        coh_mode_i = 1'b1;
        v = m_victim();
        shared_i = '0; shared_i[v] = 1'b1;
        ask_victim("R9 shared way skipped");
        owned_i = '0; owned_i[m_victim()] = 1'b1;
        ask_victim("R9 owned way skipped");
        shared_i = '1; owned_i = '0;
        ask_victim("R9 all flagged falls back to weight");
        coh_mode_i = 1'b0; shared_i = 4'b0101; owned_i = 4'b0010;
        ask_victim("R9 flags ignored with mode off");
        shared_i = '0; owned_i = '0;
    endtask

    task automatic t_priority();
        do_drop(3);
        @(negedge clk);
        touch_i = 1'b1; touch_way_i = 2'd0; fill_i = 1'b1; fill_way_i = 2'd3;
        @(negedge clk);
        touch_i = 1'b0; fill_i = 1'b0;
        while (busy_o) @(negedge clk);
        m_touch(0);
        ask_victim("R11 access wins over fill");
        @(negedge clk);
        fill_i = 1'b1; fill_way_i = 2'd3; drop_i = 1'b1; drop_way_i = 2'd1;
        @(negedge clk);
        fill_i = 1'b0; drop_i = 1'b0;
        m_valid[3] = 1'b1; m_n[3] = 0; m_w[3] = m_s;
        ask_victim("R11 fill wins over invalidate");
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 72; k++) do_touch(k % 3);
        check(m_s == WMAXI, "R2 model stamp reached limit", m_s, WMAXI);
        ask_victim("R2 R3 after saturating run");
        do_fill(2);
        ask_victim("R2 fill at saturated stamp");
        for (int k = 0; k < 3; k++) do_touch(0);
        do_fill(1);
        ask_victim("R2 R3 saturated count and stamp");
    endtask

    initial begin
        for (int i = 0; i < WAYS; i++) begin
            m_valid[i] = 1'b0; m_w[i] = 0; m_n[i] = 0;
        end
        m_s = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        wait_idle();
        t_reset();
        t_fill_all();
        t_busy_timing();
        t_ignore_busy();
        t_pattern();
        t_refill();
        t_drop();
        t_coh();
        t_priority();
        t_saturate();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(1'b0, "watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule